// File: doc/BRIEF.md
# ECC Weak-Line Probe Monitor

This block uses one cache line as a voltage-margin sensor. Each probe writes a fixed alternating pattern into a line through a simple cache write/read port and reads it back. One cycle after the read data returns, the block samples the correctable and uncorrectable flags of the external ECC decoder. Two saturating counters record the number of probes and the number of probes that showed an error. A power controller reads these counters over a window and clears them with a pulse.

A start pulse launches one of two phases. The discovery phase sweeps every set and way of a small cache. Each line gets a fixed number of probes, and the line with the most errors is kept in a target register as the weakest line. The runtime phase probes only that target line, and keeps probing for as long as the monitor stays enabled. Only one monitor per supply domain is meant to be enabled. An uncorrectable error raises a sticky alarm.

Top module: `ecc_line_monitor`

## Requirements
- R1: A probe takes four cycles: one cycle with `mem_we` high, then one cycle with `mem_re` high, then a cycle while the read returns. The ECC flags are sampled in the fourth cycle. The counters show the probe from the next cycle on, and that same cycle starts the next write.
- R2: While `mem_we` is high, `mem_wdata` holds the byte 0x5A (bits 0101 1010) repeated across the whole word.
- R3: `acc_cnt` rises by one for every completed probe. `err_cnt` rises by one for every completed probe whose sampled flags have `ecc_ce` or `ecc_ue` high.
- R4: Both counters saturate at 2^CNT_W-1 and never wrap.
- R5: A `win_clr` pulse clears both counters in the next cycle. The clear takes priority over a probe that completes in the same cycle.
- R6: When `start` is pulsed with `runtime_sel`=0, discovery visits the lines in ascending order of index set*WAYS+way. It gives each line PROBES probes, loads `tgt_set`/`tgt_way` with the line that had the most errors, and then drops `busy`.
- R7: When lines tie for the most errors in discovery, the lower set wins, and then the lower way.
- R8: When `start` is pulsed with `runtime_sel`=1, the block probes only the target line. It keeps probing back to back until `enable` goes low.
- R9: A sampled `ecc_ue` sets `alarm`, which stays high until `alarm_clr`. Correctable errors alone never set it.
- R10: While `enable` is low, no strobe is issued from the next cycle on, `start` is ignored, and the counters only change through `win_clr`.
- R11: After reset, `busy`, `alarm`, both counters, both strobes and the target (set 0, way 0) are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Selects this monitor as the active one in its domain |
| start | input | 1 | Launches a phase when idle |
| runtime_sel | input | 1 | Phase chosen at start: 0 discovery, 1 runtime |
| win_clr | input | 1 | Clears both counters |
| alarm_clr | input | 1 | Clears the sticky alarm |
| mem_we | output | 1 | Cache write strobe |
| mem_re | output | 1 | Cache read strobe |
| mem_set | output | SET_W | Set index of the access |
| mem_way | output | WAY_W | Way index of the access |
| mem_wdata | output | DATA_W | Write data (test pattern) |
| ecc_ce | input | 1 | Correctable error flag from the decoder |
| ecc_ue | input | 1 | Uncorrectable error flag from the decoder |
| tgt_set | output | SET_W | Set of the weakest line found |
| tgt_way | output | WAY_W | Way of the weakest line found |
| acc_cnt | output | CNT_W | Probe count |
| err_cnt | output | CNT_W | Error count |
| alarm | output | 1 | Sticky uncorrectable-error alarm |
| busy | output | 1 | A phase is running |

## Verification
A wrong line pointer shows within one probe as a read to an unexpected set or way, because discovery reads follow a fixed order and every runtime read must hit the target. A faulty error accumulator or comparison shows only when discovery ends, as a wrong target, about 256 cycles in the default configuration. For this reason the bench sweeps several error profiles across the lines, including ties and a maximum on the last line. Counter faults show one cycle after a sample, as a mismatch against a count kept by the bench. Saturation faults show after 255 probes.

// File: rtl/ecc_line_monitor.sv
module ecc_line_monitor #(
  parameter int SET_W  = 2,
  parameter int WAY_W  = 2,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8,
  parameter int PROBES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic              runtime_sel,
  input  logic              win_clr,
  input  logic              alarm_clr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [SET_W-1:0]  mem_set,
  output logic [WAY_W-1:0]  mem_way,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              ecc_ce,
  input  logic              ecc_ue,
  output logic [SET_W-1:0]  tgt_set,
  output logic [WAY_W-1:0]  tgt_way,
  output logic [CNT_W-1:0]  acc_cnt,
  output logic [CNT_W-1:0]  err_cnt,
  output logic              alarm,
  output logic              busy
);
  localparam int LE_W = $clog2(PROBES + 1);
  localparam int PC_W = (PROBES > 1) ? $clog2(PROBES) : 1;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_RET, S_SMP} st_t;
  st_t state;

  logic             run_mode;
  logic [SET_W-1:0] cur_set, best_set;
  logic [WAY_W-1:0] cur_way, best_way;
  logic [PC_W-1:0]  pidx;
  logic [LE_W-1:0]  line_err, best_err, line_err_nx;
  logic             hit, sample, last_probe, last_line, better;

  assign hit         = ecc_ce | ecc_ue;
  assign sample      = enable && state == S_SMP;
  assign line_err_nx = line_err + LE_W'(hit);
  assign last_probe  = pidx == PC_W'(PROBES - 1);
  assign last_line   = &cur_set && &cur_way;
  assign better      = line_err_nx > best_err;

  assign busy      = state != S_IDLE;
  assign mem_we    = state == S_WR;
  assign mem_re    = state == S_RD;
  assign mem_set   = run_mode ? tgt_set : cur_set;
  assign mem_way   = run_mode ? tgt_way : cur_way;
  assign mem_wdata = {(DATA_W / 8){8'h5A}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      run_mode <= 1'b0;
      cur_set  <= '0;
      cur_way  <= '0;
      pidx     <= '0;
      line_err <= '0;
      best_err <= '0;
      best_set <= '0;
      best_way <= '0;
      tgt_set  <= '0;
      tgt_way  <= '0;
    end else if (!enable) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state    <= S_WR;
          run_mode <= runtime_sel;
          cur_set  <= '0;
          cur_way  <= '0;
          pidx     <= '0;
          line_err <= '0;
          best_err <= '0;
          best_set <= '0;
          best_way <= '0;
        end
        S_WR:  state <= S_RD;
        S_RD:  state <= S_RET;
        S_RET: state <= S_SMP;
        S_SMP: begin
          state <= S_WR;
          if (!run_mode) begin
            if (!last_probe) begin
              pidx     <= pidx + 1'b1;
              line_err <= line_err_nx;
            end else begin
              pidx     <= '0;
              line_err <= '0;
              if (better) begin
                best_err <= line_err_nx;
                best_set <= cur_set;
                best_way <= cur_way;
              end
              if (last_line) begin
                state   <= S_IDLE;
                tgt_set <= better ? cur_set : best_set;
                tgt_way <= better ? cur_way : best_way;
              end else begin
                cur_way <= cur_way + 1'b1;
                if (&cur_way) cur_set <= cur_set + 1'b1;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || win_clr) begin
      acc_cnt <= '0;
      err_cnt <= '0;
    end else if (sample) begin
      if (acc_cnt != CMAX) acc_cnt <= acc_cnt + 1'b1;
      if (hit && err_cnt != CMAX) err_cnt <= err_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) alarm <= 1'b0;
    else if (sample && ecc_ue) alarm <= 1'b1;
    else if (alarm_clr) alarm <= 1'b0;
  end

  a_r1_read_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> $past(mem_we));
  a_r3_err_not_above_acc: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= acc_cnt);
  a_r4_acc_holds_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cnt == CMAX && !win_clr) |=> acc_cnt == CMAX);
  a_r5_window_clear: assert property (@(posedge clk) disable iff (!rst_n)
    win_clr |=> (acc_cnt == '0 && err_cnt == '0));
  a_r9_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !alarm_clr) |=> alarm);
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!mem_we && !mem_re));
endmodule

// File: tb/test_ecc_line_monitor.sv
module test_ecc_line_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 2, WW = 2, DW = 64, CW = 8, NP = 4;
  localparam int WAYS = 1 << WW;
  localparam int LINES = (1 << SW) * WAYS;
  localparam int CMAXI = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, enable = 0, start = 0, runtime_sel = 0;
  logic win_clr = 0, alarm_clr = 0, ecc_ce, ecc_ue;
  logic mem_we, mem_re, alarm, busy;
  logic [SW-1:0] mem_set, tgt_set;
  logic [WW-1:0] mem_way, tgt_way;
  logic [DW-1:0] mem_wdata;
  logic [CW-1:0] acc_cnt, err_cnt;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ecc_line_monitor #(.SET_W(SW), .WAY_W(WW), .DATA_W(DW), .CNT_W(CW), .PROBES(NP)) i_ecc_line_monitor (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .runtime_sel(runtime_sel),
    .win_clr(win_clr), .alarm_clr(alarm_clr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_set(mem_set), .mem_way(mem_way), .mem_wdata(mem_wdata), .ecc_ce(ecc_ce),
    .ecc_ue(ecc_ue), .tgt_set(tgt_set), .tgt_way(tgt_way), .acc_cnt(acc_cnt),
    .err_cnt(err_cnt), .alarm(alarm), .busy(busy));

  int errors = 0, checks = 0;
  int w [LINES];
  int rdn [LINES];
  bit ue_force = 0, rt_phase = 0;
  int exp_acc = 0, exp_err = 0, exp_line = 0, disc_ptr = 0, bad_addr = 0, bad_pat = 0;
  logic r1v = 0, r1f = 0, r2v = 0, r2f = 0;

  assign ecc_ce = r2v && r2f;
  assign ecc_ue = r2v && ue_force;

  always @(posedge clk) begin
    int l;
    l = int'(mem_set) * WAYS + int'(mem_way);
    if (!rst_n) begin
      r1v <= 0; r2v <= 0;
    end else begin
      r1v <= mem_re;
      r1f <= (rdn[l] % NP) < w[l];
      if (mem_re) begin
        rdn[l] = rdn[l] + 1;
        if (rt_phase && l != exp_line) bad_addr = bad_addr + 1;
        if (!rt_phase) begin
          if (l != disc_ptr / NP) bad_addr = bad_addr + 1;
          disc_ptr = disc_ptr + 1;
        end
      end
      if (mem_we && mem_wdata != {(DW / 8){8'h5A}}) bad_pat = bad_pat + 1;
      r2v <= r1v;
      r2f <= r1f;
      if (win_clr) begin
        exp_acc = 0; exp_err = 0;
      end else if (r2v && enable && busy) begin
        if (exp_acc < CMAXI) exp_acc = exp_acc + 1;
        if ((r2f || ue_force) && exp_err < CMAXI) exp_err = exp_err + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk) win_clr = 1;
    @(negedge clk) win_clr = 0;
  endtask

  task automatic do_start(input bit rt);
    @(negedge clk) start = 1; runtime_sel = rt;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic discovery(input string req);
    int best, mx, sum;
    best = 0; mx = -1; sum = 0;
    for (int l = 0; l < LINES; l++) begin
      sum += (w[l] > NP) ? NP : w[l];
      if (w[l] > mx) begin mx = w[l]; best = l; end
    end
    rt_phase = 0; disc_ptr = 0; bad_addr = 0;
    pulse_clr();
    do_start(0);
    wait_idle();
    check(!busy, "R6 busy drops", busy, 0);
    check(int'(tgt_set) * WAYS + int'(tgt_way) == best, req,
          int'(tgt_set) * WAYS + int'(tgt_way), best);
    check(acc_cnt == LINES * NP, "R3 discovery acc", acc_cnt, LINES * NP);
    check(err_cnt == sum, "R3 discovery err", err_cnt, sum);
    check(bad_addr == 0, "R6 sweep order", bad_addr, 0);
    check(!alarm, "R9 ce-only no alarm", alarm, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t;
    for (int l = 0; l < LINES; l++) begin w[l] = 0; rdn[l] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !alarm && !mem_we && !mem_re, "R11 reset idle", busy, 0);
    check(acc_cnt == 0 && err_cnt == 0, "R11 reset counters", acc_cnt + err_cnt, 0);
    check(tgt_set == 0 && tgt_way == 0, "R11 reset target", tgt_set * WAYS + tgt_way, 0);

    do_start(0);
    check(busy == 0, "R10 start ignored when disabled", busy, 0);
    enable = 1;

    for (int l = 0; l < LINES; l++) w[l] = 1;
    @(negedge clk) start = 1; runtime_sel = 0;
    @(negedge clk) start = 0;
    check(mem_we && !mem_re, "R1 write first", mem_we, 1);
    check(mem_wdata == {(DW / 8){8'h5A}}, "R2 pattern", int'(mem_wdata[7:0]), 8'h5A);
    @(negedge clk);
    check(!mem_we && mem_re, "R1 read second", mem_re, 1);
    @(negedge clk);
    check(!mem_we && !mem_re, "R1 return cycle idle", mem_re, 0);
    @(negedge clk);
    check(acc_cnt == 0, "R1 not yet counted in sample cycle", acc_cnt, 0);
    @(negedge clk);
    check(acc_cnt == 1 && err_cnt == 1, "R1 counted after sample", acc_cnt, 1);
    check(mem_we, "R1 next probe starts", mem_we, 1);
    wait_idle();

    for (int k = 1; k <= 6; k++) begin
      for (int l = 0; l < LINES; l++) w[l] = (l * k + 3 * k) % 5;
      discovery("R6 weakest line");
    end
    for (int l = 0; l < LINES; l++) w[l] = 2;
    discovery("R7 full tie picks set0 way0");
    for (int l = 0; l < LINES; l++) w[l] = (l % WAYS == 2 && l / WAYS >= 1) ? 3 : l % 2;
    discovery("R7 tie lower set wins");
    for (int l = 0; l < LINES; l++) w[l] = (l == LINES - 1) ? 4 : 3;
    discovery("R6 last line max");
    for (int l = 0; l < LINES; l++) w[l] = (l == 6) ? 3 : 0;
    discovery("R6 set1 way2");
    check(tgt_set == 1 && tgt_way == 2, "R6 target fields", tgt_set * WAYS + tgt_way, 6);

    exp_line = 6; w[6] = 4; rt_phase = 1; bad_addr = 0; bad_pat = 0;
    pulse_clr();
    do_start(1);
    repeat (400) @(negedge clk);
    check(exp_acc > 60 && acc_cnt == exp_acc, "R8 runtime acc", acc_cnt, exp_acc);
    check(err_cnt == exp_err, "R3 runtime err", err_cnt, exp_err);
    pulse_clr();
    check(acc_cnt == 0 && err_cnt == 0, "R5 window clear", acc_cnt, 0);
    repeat (1200) @(negedge clk);
    check(busy, "R8 still probing", busy, 1);
    check(acc_cnt == CMAXI, "R4 acc saturates", acc_cnt, CMAXI);
    check(err_cnt == CMAXI, "R4 err saturates", err_cnt, CMAXI);
    check(bad_addr == 0, "R8 only target read", bad_addr, 0);
    check(bad_pat == 0, "R2 pattern every write", bad_pat, 0);

    pulse_clr();
    repeat (37) @(negedge clk);
    enable = 0;
    @(negedge clk);
    check(!mem_we && !mem_re && !busy, "R10 stop strobes", mem_re, 0);
    t = acc_cnt;
    check(acc_cnt == exp_acc && err_cnt == exp_err, "R3 partial window", acc_cnt, exp_acc);
    do_start(1);
    repeat (10) @(negedge clk);
    check(acc_cnt == t && !busy, "R10 counters hold", acc_cnt, t);

    enable = 1; ue_force = 1; w[6] = 0;
    do_start(1);
    for (int i = 0; i < 20 && !alarm; i++) @(negedge clk);
    check(alarm, "R9 ue sets alarm", alarm, 1);
    ue_force = 0;
    repeat (20) @(negedge clk);
    check(alarm, "R9 alarm sticky", alarm, 1);
    @(negedge clk) alarm_clr = 1;
    @(negedge clk) alarm_clr = 0;
    check(!alarm, "R9 alarm cleared", alarm, 0);
    enable = 0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule